// File: doc/BRIEF.md
# Return-from-Interrupt Machine State Restore

This block computes the machine state that a return-from-interrupt instruction installs, along with the address where fetch resumes. It takes three 64-bit values: the live machine state register, the saved return address and the saved machine state. From these it forms the new machine state and the redirect target. The logic is purely combinational, so the results follow the inputs within the same cycle. The pipeline stage that holds it registers them.

The restore does not simply copy the saved state. Most fields come straight from the saved copy. When the saved problem-state bit is set, it forces the external-interrupt enable and both address-translation enables on. A three-bit transaction-state field is protected against one illegal transition. A small set of fields is left at its current value. The return address loses its two low bits so that it is word aligned. Both results carry a valid flag that follows the instruction-valid input.

Bit numbers below are MSB-0: bit k is vector index 63-k.

Top module: `rfi_msr_restore`

## Requirements
- R1: New-state bits 0-2, 4-28, 32, 37-41, 49-50, 52-57 and 60-63 equal the same bits of the saved state.
- R2: New-state bit 3 (hypervisor, index 60) equals saved-state bit 3.
- R3: New-state bits 48 (index 15), 58 (index 5) and 59 (index 4) each equal the saved bit OR saved bit 49 (problem state, index 14).
- R4: New-state bits 29-31 (indices 34:32) keep the current value when current bits 29-31 are 010 and saved bits 29-31 are 000. In every other case they take the saved value.
- R5: New-state bits 33-36, 42-47 and 51 keep the current-state value and ignore the saved state.
- R6: The next address equals the saved return address with indices 1:0 forced to zero.
- R7: While the instruction-valid input is high, both the state-valid and address-valid outputs are high.
- R8: While the instruction-valid input is low, both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_valid | input | 1 | A return-from-interrupt instruction is present |
| cur_msr | input | 64 | Live machine state |
| saved_pc | input | 64 | Saved return address |
| saved_msr | input | 64 | Saved machine state |
| new_msr | output | 64 | Restored machine state |
| new_msr_vld | output | 1 | new_msr is to be written |
| next_pc | output | 64 | Fetch redirect address |
| next_pc_vld | output | 1 | next_pc is to be taken |

## Verification
Every result is due in the same cycle as its stimulus because no register lies between the inputs and the outputs. The bench changes inputs on the falling clock edge and samples one nanosecond later, after the logic has settled and before the next rising edge. Each vector is compared field group by field group against a model built from the MSB-0 bit lists. The stimulus is biased toward the transaction-state corner and toward a set problem-state bit.

// File: rtl/rfi_msr_restore.sv
module rfi_msr_restore (
  input  logic        insn_valid,
  input  logic [63:0] cur_msr,
  input  logic [63:0] saved_pc,
  input  logic [63:0] saved_msr,
  output logic [63:0] new_msr,
  output logic        new_msr_vld,
  output logic [63:0] next_pc,
  output logic        next_pc_vld
);
  localparam int HV_I  = 60;
  localparam int EE_I  = 15;
  localparam int PR_I  = 14;
  localparam int IR_I  = 5;
  localparam int DR_I  = 4;

  function automatic logic [63:0] build_keep();
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++)
      if ((k >= 33 && k <= 36) || (k >= 42 && k <= 47) || k == 51) m[63-k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] build_special();
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++)
      if (k == 3 || (k >= 29 && k <= 31) || k == 48 || k == 58 || k == 59) m[63-k] = 1'b1;
    return m;
  endfunction

  localparam logic [63:0] KEEP_M = build_keep();
  localparam logic [63:0] COPY_M = ~(KEEP_M | build_special());

  logic [2:0]  cur_ts, sav_ts;
  logic        ts_hold;
  logic [63:0] base;

  assign cur_ts  = cur_msr[34:32];
  assign sav_ts  = saved_msr[34:32];
  assign ts_hold = (cur_ts == 3'b010) && (sav_ts == 3'b000);
  assign base    = (saved_msr & COPY_M) | (cur_msr & KEEP_M);

  always_comb begin
    new_msr        = base;
    new_msr[HV_I]  = saved_msr[HV_I];
    new_msr[34:32] = ts_hold ? cur_ts : sav_ts;
    new_msr[EE_I]  = saved_msr[EE_I] | saved_msr[PR_I];
    new_msr[IR_I]  = saved_msr[IR_I] | saved_msr[PR_I];
    new_msr[DR_I]  = saved_msr[DR_I] | saved_msr[PR_I];
  end

  assign next_pc     = {saved_pc[63:2], 2'b00};
  assign new_msr_vld = insn_valid;
  assign next_pc_vld = insn_valid;
endmodule

// File: rtl/rfi_msr_restore_chk.sv
module rfi_msr_restore_chk (
  input logic        insn_valid,
  input logic [63:0] cur_msr,
  input logic [63:0] saved_pc,
  input logic [63:0] saved_msr,
  input logic [63:0] new_msr,
  input logic        new_msr_vld,
  input logic [63:0] next_pc,
  input logic        next_pc_vld
);
  always_comb begin
    // R3
    pr_forces_on_chk: assert (!saved_msr[14] || (new_msr[15] && new_msr[5] && new_msr[4]))
      else $error("problem state did not force enables");
    // R4
    ts_guard_chk: assert (!(cur_msr[34:32] == 3'b010 && saved_msr[34:32] == 3'b000) ||
                          new_msr[34:32] == 3'b010)
      else $error("transaction field guard broken");
    // R5
    kept_field_chk: assert (new_msr[30:27] == cur_msr[30:27] && new_msr[21:16] == cur_msr[21:16])
      else $error("kept field changed");
    // R6
    pc_align_chk: assert (next_pc[1:0] == 2'b00 && next_pc[63:2] == saved_pc[63:2])
      else $error("return address not aligned");
    // R7
    vld_on_chk: assert (!insn_valid || (new_msr_vld && next_pc_vld))
      else $error("valid flag missing");
    // R8
    vld_off_chk: assert (insn_valid || (!new_msr_vld && !next_pc_vld))
      else $error("valid flag while idle");
  end
endmodule

bind rfi_msr_restore rfi_msr_restore_chk i_chk (.*);

// File: tb/test_rfi_msr_restore.sv
module test_rfi_msr_restore;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        insn_valid = 1'b0;
  logic [63:0] cur_msr = '0, saved_pc = '0, saved_msr = '0;
  logic [63:0] new_msr, next_pc;
  logic        new_msr_vld, next_pc_vld;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  rfi_msr_restore i_rfi_msr_restore (.*);

  // group of an MSB-0 bit: 1 copy, 2 hv, 3 forced, 4 ts, 5 kept
  function automatic int grp(int k);
    if (k == 3) return 2;
    if (k == 48 || k == 58 || k == 59) return 3;
    if (k >= 29 && k <= 31) return 4;
    if ((k >= 33 && k <= 36) || (k >= 42 && k <= 47) || k == 51) return 5;
    return 1;
  endfunction

  function automatic logic [63:0] gmask(int g);
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++) if (grp(k) == g) m[63-k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] model(logic [63:0] c, logic [63:0] s);
    logic [63:0] r = '0;
    bit hold = (c[34:32] == 3'b010) && (s[34:32] == 3'b000);
    for (int k = 0; k < 64; k++) begin
      case (grp(k))
        3: r[63-k] = s[63-k] | s[63-49];
        4: r[63-k] = hold ? c[63-k] : s[63-k];
        5: r[63-k] = c[63-k];
        default: r[63-k] = s[63-k];
      endcase
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(bit v, logic [63:0] c, logic [63:0] p, logic [63:0] s);
    logic [63:0] e;
    @(negedge clk);
    insn_valid = v; cur_msr = c; saved_pc = p; saved_msr = s;
    #1;
    e = model(c, s);
    chk("R1", new_msr & gmask(1), e & gmask(1));
    chk("R2", new_msr & gmask(2), e & gmask(2));
    chk("R3", new_msr & gmask(3), e & gmask(3));
    chk("R4", new_msr & gmask(4), e & gmask(4));
    chk("R5", new_msr & gmask(5), e & gmask(5));
    chk("R6", next_pc, p & ~64'h3);
    if (v) chk("R7", {62'd0, new_msr_vld, next_pc_vld}, 64'd3);
    else   chk("R8", {62'd0, new_msr_vld, next_pc_vld}, 64'd0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    chk("R8", {62'd0, new_msr_vld, next_pc_vld}, 64'd0);
    // R4 corners
    apply(1, 64'h0000_0002_0000_0000, 64'h1000, 64'h0);
    apply(1, 64'h0000_0002_0000_0000, 64'h1003, 64'h0000_0001_0000_0000);
    apply(1, 64'h0000_0003_0000_0000, 64'h1001, 64'h0);
    apply(1, 64'h0000_0002_FFFF_FFFF, 64'h2, 64'hFFFF_FFF8_0000_0000);
    // R3 problem state with enables clear
    apply(1, '0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_4000);
    // R5 kept fields vs all-ones saved
    apply(1, '0, 64'h7, '1);
    apply(1, '1, '0, '0);
    // R2 hypervisor bit both ways
    apply(1, '0, '0, 64'h1000_0000_0000_0000);
    apply(1, '1, '0, 64'hEFFF_FFFF_FFFF_FFFF);
    apply(0, r64(), r64(), r64());
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] c = r64(), s = r64();
      if (i % 4 == 0) c[34:32] = 3'b010;
      if (i % 8 == 0) s[34:32] = 3'b000;
      if (i % 3 == 0) s[14] = 1'b1;
      apply($urandom_range(0, 4) != 0, c, r64(), s);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule